// File: doc/BRIEF.md
# Three-Phase Gate Driver Dead-Band and Polarity Stage

This block sits after the duty-cycle compare logic of a three-phase motor waveform generator. It turns each of the three raw phase signals into a pair of complementary gate commands, one for the upper switch of the bridge leg and one for the lower switch, giving six gate outputs in all. On every change of a raw phase signal, the switch that must turn off is released at once. The switch that must turn on is held off for a programmable dead band, so that the two switches of a leg never conduct together.

The dead band is a 6-bit value. Each unit is eight clock periods, so the longest dead band is 504 clocks. The value is captured only while the generator is disabled, and changes made while it runs are ignored. After the dead band, the upper group and the lower group of outputs each pass through their own polarity selection, which picks an active-high or an active-low output level. While the generator is disabled, all six outputs sit at their inactive level.

Top module: `gate_deadband`

## Requirements
- R1: After a raw phase signal changes, the output that turns on becomes active only when `run_en` has been 1 and the raw signal has held its new level over 8×D+1 consecutive clock samples. D is the captured dead-band value. The output changes one clock after the last of those samples.
- R2: When a raw phase signal is sampled at 1 while enabled, the lower output of that leg is inactive from the next clock on.
- R3: When a raw phase signal is sampled at 0 while enabled, the upper output of that leg is inactive from the next clock on.
- R4: A raw pulse that holds its level for 8×D or fewer samples produces no active pulse on the output it would have turned on.
- R5: With D = 0, the upper output of a leg follows the raw signal and the lower output follows its inverse, each one clock after the sample.
- R6: The upper and lower outputs of a leg are never active in the same cycle.
- R7: `pol_upper` = 1 makes the upper outputs active high. `pol_upper` = 0 makes them active low.
- R8: `pol_lower` sets the lower outputs with the same encoding: 1 means active high and 0 means active low.
- R9: One clock after `run_en` is sampled at 0, all six outputs are at their inactive level. After `run_en` returns to 1, no output becomes active until a full dead band has passed.
- R10: `dead_band` is captured only on clocks where `run_en` is 0. A change of `dead_band` while enabled has no effect on the delay.
- R11: During synchronous reset (`rst_n` = 0), all six outputs go to their inactive level, and the captured dead band is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Waveform output enable; 0 forces all outputs inactive |
| dead_band | input | 6 | Dead-band length in units of eight clocks |
| pol_upper | input | 1 | Upper group active level: 1 high, 0 low |
| pol_lower | input | 1 | Lower group active level: 1 high, 0 low |
| phase_raw | input | 3 | Raw duty signal of each phase, bit 0 = first phase |
| gate_upper | output | 3 | Upper switch gate commands, bit n for phase n |
| gate_lower | output | 3 | Lower switch gate commands, bit n for phase n |

## Verification
The bench aims at the exact cycle in which the delayed switch turns on. A design with an off-by-one dead-band counter would turn that switch on one clock early or one clock late. The bench sends raw pulses of exactly 8×D and 8×D+1 samples. A counter that is not cleared on a short pulse would emit a sliver of on-time, or leave both switches of a leg on. The bench rewrites the dead band while running and toggles the enable. These steps expose a design that reads the live dead-band value, or one that turns a switch on straight after re-enable without waiting out the dead band. Random polarity settings catch a swapped or shared polarity bit between the two output groups.

// File: rtl/gate_deadband_pkg.sv
// Package: shared widths and types for the gate dead-band stage.
// Assumes one dead-band unit is a power of two of clock periods.
package gate_deadband_pkg;
    localparam int DB_W       = 6;  // width of the dead-band setting
    localparam int UNIT_LOG2  = 3;  // one unit = 2**UNIT_LOG2 clocks
    localparam int LEGS       = 3;  // number of bridge legs
    localparam int CNT_W      = DB_W + UNIT_LOG2;

    typedef logic [DB_W-1:0]  db_t;
    typedef logic [CNT_W-1:0] cnt_t;

    // Active-high switch request of one bridge leg
    typedef struct packed {
        logic up_on;
        logic lo_on;
    } leg_req_t;

    // Convert a dead-band setting into a clock count
    function automatic cnt_t db_to_clocks(input db_t db);
        return {db, {UNIT_LOG2{1'b0}}};
    endfunction
endpackage

// File: rtl/gate_deadband_cfg.sv
// Module: gate_deadband_cfg
// Captures the dead-band setting while the generator is disabled and
// registers the run enable that all legs share.
// Assumes software only changes the dead band while disabled; any
// change made while running is held off until the next disable.
module gate_deadband_cfg
    import gate_deadband_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  db_t  dead_band,
    output db_t  db_held,
    output logic run_q
);
    // Capture the dead band on disabled clocks only, and register the enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            db_held <= '0;
            run_q   <= 1'b0;
        end else begin
            if (!run_en) begin
                db_held <= dead_band;
            end
            run_q <= run_en;
        end
    end

    // The held value is frozen across consecutive enabled clocks
    p_db_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && run_en) |=> $stable(db_held));
endmodule

// File: rtl/gate_deadband_leg.sv
// Module: gate_deadband_leg
// Dead-band generator for one bridge leg. It turns a raw phase signal
// into active-high upper and lower switch requests. The switch being
// released drops one clock after the sample, and the switch being
// engaged waits until the raw level has been stable over delay+1 samples.
// Assumes db_held is constant while run_q is 1.
module gate_deadband_leg
    import gate_deadband_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run_en,
    input  logic     run_q,
    input  db_t      db_held,
    input  logic     raw_in,
    output leg_req_t req
);
    logic raw_q;
    cnt_t stable_cnt;
    cnt_t delay_clk;
    logic settled;

    assign delay_clk = db_to_clocks(db_held);
    assign settled   = (stable_cnt >= delay_clk);

    // Track the raw level and count clocks since its last change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q      <= 1'b0;
            stable_cnt <= '0;
        end else begin
            raw_q <= raw_in;
            if (!run_en || (raw_in != raw_q)) begin
                stable_cnt <= '0;
            end else if (stable_cnt < delay_clk) begin
                stable_cnt <= stable_cnt + 1'b1;
            end
        end
    end

    // Engage a switch only when enabled and its level has settled
    always_comb begin
        req.up_on = run_q &&  raw_q && settled;
        req.lo_on = run_q && !raw_q && settled;
    end

    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(req.up_on && req.lo_on));
    p_lower_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && raw_in) |=> !req.lo_on);
    p_upper_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !raw_in) |=> !req.up_on);
    p_idle_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!req.up_on && !req.lo_on));
    p_edge_waits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && (raw_in != raw_q) && (db_held != '0)) |=>
            (!req.up_on && !req.lo_on));
endmodule

// File: rtl/gate_deadband_pol.sv
// Module: gate_deadband_pol
// Maps active-high switch requests onto pin levels. The upper group
// and the lower group have separate polarity selects, where 1 means
// active high. A leg that is not requested drives the inactive level.
module gate_deadband_pol
    import gate_deadband_pkg::*;
(
    input  leg_req_t         req [LEGS],
    input  logic             pol_upper,
    input  logic             pol_lower,
    output logic [LEGS-1:0]  gate_upper,
    output logic [LEGS-1:0]  gate_lower
);
    for (genvar g = 0; g < LEGS; g++) begin : g_pin
        // Apply each group's polarity to its request
        always_comb begin
            gate_upper[g] = pol_upper ? req[g].up_on : !req[g].up_on;
            gate_lower[g] = pol_lower ? req[g].lo_on : !req[g].lo_on;
        end
    end
endmodule

// File: rtl/gate_deadband.sv
// Module: gate_deadband (top)
// Three-phase dead-band insertion and output polarity stage. Each raw
// phase is split into an upper and a lower gate command with a
// programmable dead band of 8-clock units.
// Assumes phase_raw is synchronous to clk.
module gate_deadband
    import gate_deadband_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_en,
    input  logic [5:0]      dead_band,
    input  logic            pol_upper,
    input  logic            pol_lower,
    input  logic [2:0]      phase_raw,
    output logic [2:0]      gate_upper,
    output logic [2:0]      gate_lower
);
    db_t      db_held;
    logic     run_q;
    leg_req_t req [LEGS];

    gate_deadband_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .dead_band (dead_band),
        .db_held   (db_held),
        .run_q     (run_q)
    );

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        gate_deadband_leg u_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .run_en  (run_en),
            .run_q   (run_q),
            .db_held (db_held),
            .raw_in  (phase_raw[g]),
            .req     (req[g])
        );
    end

    gate_deadband_pol u_pol (
        .req        (req),
        .pol_upper  (pol_upper),
        .pol_lower  (pol_lower),
        .gate_upper (gate_upper),
        .gate_lower (gate_lower)
    );
endmodule

// File: tb/gate_deadband_test.sv
// Bench for gate_deadband: a reference model built from the requirements,
// directed corner cases and seeded random stimulus.
module gate_deadband_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic [5:0] dead_band = '0;
    logic       pol_upper = 1'b1;
    logic       pol_lower = 1'b1;
    logic [2:0] phase_raw = '0;
    logic [2:0] gate_upper;
    logic [2:0] gate_lower;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Model state: captured dead band, previous raw sample, samples stable
    int  m_db = 0;
    bit  m_run = 0;
    bit  m_prev [3];
    int  m_stable [3];
    bit  m_up [3];
    bit  m_lo [3];

    gate_deadband uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .dead_band(dead_band),
        .pol_upper(pol_upper), .pol_lower(pol_lower), .phase_raw(phase_raw),
        .gate_upper(gate_upper), .gate_lower(gate_lower)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit pin_level(input bit on, input bit pol);
        return pol ? on : !on;
    endfunction

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Model update at a clock edge, following R1, R9, R10 and R11
    task automatic model_edge();
        for (int g = 0; g < 3; g++) begin
            if (!rst_n) begin
                m_prev[g] = 0; m_stable[g] = 0;
            end else begin
                if (!run_en || phase_raw[g] != m_prev[g]) m_stable[g] = 0;
                else if (m_stable[g] < 8*m_db) m_stable[g]++;
                m_prev[g] = phase_raw[g];
            end
        end
        if (!rst_n) begin m_db = 0; m_run = 0; end
        else begin
            if (!run_en) m_db = dead_band;
            m_run = run_en;
        end
        for (int g = 0; g < 3; g++) begin
            m_up[g] = m_run &&  m_prev[g] && (m_stable[g] >= 8*m_db);
            m_lo[g] = m_run && !m_prev[g] && (m_stable[g] >= 8*m_db);
        end
    endtask

    function automatic logic [2:0] exp_upper();
        logic [2:0] v;
        for (int g = 0; g < 3; g++) v[g] = pin_level(m_up[g], pol_upper);
        return v;
    endfunction

    function automatic logic [2:0] exp_lower();
        logic [2:0] v;
        for (int g = 0; g < 3; g++) v[g] = pin_level(m_lo[g], pol_lower);
        return v;
    endfunction

    // One clock: model at the edge, compare at the falling edge
    task automatic step();
        logic [2:0] up_on, lo_on;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cycles++;
        check("R1/R5/R7/R8/R9/R10 model upper", gate_upper, exp_upper());
        check("R1/R5/R7/R8/R9/R10 model lower", gate_lower, exp_lower());
        up_on = pol_upper ? gate_upper : ~gate_upper;
        lo_on = pol_lower ? gate_lower : ~gate_lower;
        check("R6 no overlap", up_on & lo_on, 3'b000);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        bit seen;
        void'($urandom(32'd2024));
        // R11: reset state with active-high groups
        rst_n = 1'b0; run_en = 1'b1; dead_band = 6'd5; phase_raw = 3'b101;
        steps(3);
        check("R11 reset upper", gate_upper, 3'b000);
        check("R11 reset lower", gate_lower, 3'b000);

        // R5: zero dead band gives plain complementary outputs
        rst_n = 1'b1; run_en = 1'b0; dead_band = 6'd0; phase_raw = 3'b000;
        step();
        run_en = 1'b1; step();
        phase_raw = 3'b011; step();
        check("R5 complementary upper", gate_upper, 3'b011);
        check("R5 complementary lower", gate_lower, 3'b100);

        // R1/R2: rising edge with one unit of dead band (8 clocks)
        run_en = 1'b0; dead_band = 6'd1; phase_raw = 3'b000; step();
        run_en = 1'b1; steps(12);
        check("R9 re-enable after dead band lower", gate_lower, 3'b111);
        phase_raw[0] = 1'b1; step();
        check("R2 lower drops at once", gate_lower, 3'b110);
        check("R1 upper still held", gate_upper, 3'b000);
        steps(7);
        check("R1 upper held through dead band", gate_upper, 3'b000);
        step();
        check("R1 upper on after 8 clocks", gate_upper, 3'b001);

        // R3: falling edge drops upper at once, lower waits
        phase_raw[0] = 1'b0; step();
        check("R3 upper drops at once", gate_upper, 3'b000);
        check("R3 lower held", gate_lower, 3'b110);
        steps(8);
        check("R1 lower on after dead band", gate_lower, 3'b111);

        // R4: a pulse of exactly 8 samples never turns upper on
        seen = 0;
        phase_raw[1] = 1'b1;
        for (int i = 0; i < 8; i++) begin step(); if (gate_upper[1]) seen = 1; end
        phase_raw[1] = 1'b0;
        for (int i = 0; i < 10; i++) begin step(); if (gate_upper[1]) seen = 1; end
        check("R4 short pulse suppressed", {2'b00, seen}, 3'b000);
        // 9 samples is just long enough for one clock of on-time
        phase_raw[1] = 1'b1; steps(9);
        check("R1 boundary pulse turns on", gate_upper, 3'b010);
        phase_raw[1] = 1'b0; steps(9);

        // R10: dead band written while running is ignored
        dead_band = 6'd0; phase_raw[2] = 1'b1; steps(2);
        check("R10 live change ignored", gate_upper, 3'b000);
        steps(8);
        check("R10 old dead band kept", gate_upper, 3'b100);

        // R7/R8/R9: active-low groups, then disable
        pol_upper = 1'b0; pol_lower = 1'b0; step();
        check("R7 upper active low", gate_upper, 3'b011);
        check("R8 lower active low", gate_lower, 3'b100);
        run_en = 1'b0; step();
        check("R9 disabled upper inactive", gate_upper, 3'b111);
        check("R9 disabled lower inactive", gate_lower, 3'b111);

        // Random stimulus against the model
        for (int blk = 0; blk < 60; blk++) begin
            pol_upper = $urandom_range(0, 1);
            pol_lower = $urandom_range(0, 1);
            run_en = 1'b0; dead_band = 6'($urandom_range(0, 3)); step();
            run_en = 1'b1;
            for (int i = 0; i < 300; i++) begin
                for (int g = 0; g < 3; g++)
                    if ($urandom_range(0, 19) == 0) phase_raw[g] = ~phase_raw[g];
                if ($urandom_range(0, 99) == 0) dead_band = 6'($urandom);
                if ($urandom_range(0, 199) == 0) run_en = ~run_en;
                step();
            end
        end

        // Largest dead band: 504 clocks before turn-on
        run_en = 1'b0; dead_band = 6'd63; phase_raw = 3'b000; pol_upper = 1; pol_lower = 1;
        step();
        run_en = 1'b1; steps(510);
        phase_raw = 3'b111; steps(504);
        check("R1 max dead band held", gate_upper, 3'b000);
        step();
        check("R1 max dead band on", gate_upper, 3'b111);
        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        int n;
        n = 0;
        while (!done && n < WATCHDOG) begin @(posedge clk); n++; end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule